// File: doc/BRIEF.md
# Multiplex-Mode Segment Bitmap Packer

This block takes a stream of 8-bit display data bytes and stores them in a bit-mapped segment memory. The memory has four rows and, by default, 160 columns. Row n holds the segment states shown while backplane n is active, and column c drives segment line c. The way each byte is spread over the memory depends on the selected multiplex drive mode. In static mode a byte becomes eight one-bit column words. In the 1:2, 1:3 and 1:4 modes the same eight bits fill column words that are two, three or four rows tall.

Every byte is committed in the cycle it is presented. A column pointer then steps forward by the number of columns the byte covered, and wraps past the last column. A separate load port sets the pointer to any column. A combinational read port returns the 4-bit word of any column to the scan-out logic. Mode selection is a registered setting that is written through its own strobe.

Top module: `lcd_seg_packer`

## Requirements
- R1: With mode code 0 (static), a byte presented at pointer p writes bit 7 to column p row 0, bit 6 to column p+1 row 0, and so on down to bit 0 at column p+7 row 0. Rows 1 to 3 are not touched.
- R2: With mode code 1 (1:2), bits 7 and 6 go to rows 0 and 1 of column p, bits 5 and 4 to column p+1, bits 3 and 2 to column p+2, and bits 1 and 0 to column p+3. Rows 2 and 3 are not touched.
- R3: With mode code 2 (1:3), bits 7, 6 and 5 go to rows 0, 1 and 2 of column p, and bits 4, 3 and 2 go to rows 0, 1 and 2 of column p+1. Bits 1 and 0 go to rows 0 and 1 of column p+2. Row 2 of column p+2 keeps its previous value, and row 3 is not touched.
- R4: With mode code 3 (1:4), bits 7 to 4 go to rows 0 to 3 of column p, and bits 3 to 0 go to rows 0 to 3 of column p+1.
- R5: After each accepted byte the pointer advances by 8, 4, 3 or 2 columns for mode codes 0, 1, 2 and 3. With no byte and no valid load, the pointer holds its value.
- R6: Column addresses and the pointer count modulo the column count. Column 159 is followed by column 0, and the pointer always stays below the column count.
- R7: A pointer load with a value below the column count sets the pointer in the next cycle and overrides the advance. A byte presented in the same cycle is written at the old pointer. A load value at or above the column count is ignored.
- R8: Written data is visible on the read port from the cycle after the write edge. A read of a column that is being written in the same cycle returns the old contents.
- R9: The read port is combinational and returns 0 for a read address at or above the column count.
- R10: After reset the pointer is 0 and the mode is static (code 0). A mode write takes effect from the next cycle, so a byte presented in the same cycle uses the old mode. Memory contents are undefined after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we_i | input | 1 | Load strobe for the mode register |
| mode_sel_i | input | 2 | Mode code: 0 static, 1 1:2, 2 1:3, 3 1:4 |
| ptr_ld_i | input | 1 | Pointer load strobe |
| ptr_val_i | input | CW (8) | Column to load into the pointer |
| byte_vld_i | input | 1 | Display byte present this cycle |
| byte_i | input | BYTE_W (8) | Display data byte |
| rd_addr_i | input | CW (8) | Scan-out column address |
| rd_data_o | output | 4 | Column word, bit n is row n |
| ptr_o | output | CW (8) | Current column pointer |

## Verification
The bench builds the block with the default 160 columns and 8-bit bytes. These values make the pointer 8 bits wide, so the bench can drive load values from 160 to 255 to check that illegal loads are ignored, and it can drive read addresses past the last column. Eighty bytes in 1:4 mode cover every column once and bring the pointer back to 0. This initialises the whole memory, so every later read can be compared in full. It also lets the bench check the untouched row-2 bit left by 1:3 mode against a known earlier value.

// File: rtl/lcd_pack_pkg.sv
package lcd_pack_pkg;
   localparam int unsigned NUM_ROWS = 4;

   typedef enum logic [1:0] {
      MUX_STATIC = 2'd0,
      MUX_TWO    = 2'd1,
      MUX_THREE  = 2'd2,
      MUX_FOUR   = 2'd3
   } mux_mode_e;
endpackage

// File: rtl/lcd_bit_mapper.sv
// Spreads one byte into per-bit (column, row, value) write requests.
module lcd_bit_mapper
   import lcd_pack_pkg::*;
#(
   parameter int unsigned COLS   = 160,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CW     = $clog2(COLS)
) (
   input  mux_mode_e         mode_i,
   input  logic [CW-1:0]     base_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic [CW-1:0]     col_o [BYTE_W],
   output logic [1:0]        row_o [BYTE_W],
   output logic [BYTE_W-1:0] bit_o,
   output logic [CW-1:0]     step_o
);
   localparam logic [CW:0] COLS_X = (CW+1)'(COLS);

   for (genvar j = 0; j < BYTE_W; j++) begin : g_bit
      localparam int unsigned J = j;
      logic [CW-1:0] off_w;
      logic [1:0]    row_w;
      logic [CW:0]   sum_w;

      always_comb begin
         unique case (mode_i)
            MUX_STATIC: begin off_w = CW'(J);     row_w = 2'd0;       end
            MUX_TWO:    begin off_w = CW'(J / 2); row_w = 2'(J % 2);  end
            MUX_THREE:  begin off_w = CW'(J / 3); row_w = 2'(J % 3);  end
            default:    begin off_w = CW'(J / 4); row_w = 2'(J % 4);  end
         endcase
         sum_w = {1'b0, base_i} + {1'b0, off_w};
      end

      assign col_o[j] = (sum_w >= COLS_X) ? CW'(sum_w - COLS_X) : sum_w[CW-1:0];
      assign row_o[j] = row_w;
      assign bit_o[j] = byte_i[BYTE_W-1-j];
   end

   always_comb begin
      unique case (mode_i)
         MUX_STATIC: step_o = CW'(BYTE_W);
         MUX_TWO:    step_o = CW'((BYTE_W + 1) / 2);
         MUX_THREE:  step_o = CW'((BYTE_W + 2) / 3);
         default:    step_o = CW'((BYTE_W + 3) / 4);
      endcase
   end
endmodule

// File: rtl/lcd_col_ptr.sv
// Column pointer with modular advance and range-checked load.
module lcd_col_ptr #(
   parameter int unsigned COLS = 160,
   parameter int unsigned CW   = $clog2(COLS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_i,
   input  logic [CW-1:0] step_i,
   input  logic          ld_i,
   input  logic [CW-1:0] ld_val_i,
   output logic [CW-1:0] ptr_o
);
   localparam logic [CW:0] COLS_X = (CW+1)'(COLS);

   logic [CW-1:0] ptr_q, ptr_d;
   logic [CW:0]   sum_w;
   logic          ld_ok;

   always_comb begin
      sum_w = {1'b0, ptr_q} + {1'b0, step_i};
      ld_ok = ld_i && ({1'b0, ld_val_i} < COLS_X);
      if (ld_ok)
         ptr_d = ld_val_i;
      else if (adv_i)
         ptr_d = (sum_w >= COLS_X) ? CW'(sum_w - COLS_X) : sum_w[CW-1:0];
      else
         ptr_d = ptr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
   end

   assign ptr_o = ptr_q;
endmodule

// File: rtl/lcd_bitmap_mem.sv
// Row-by-column bit store with per-bit writes and a combinational column read.
module lcd_bitmap_mem
   import lcd_pack_pkg::*;
#(
   parameter int unsigned COLS   = 160,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CW     = $clog2(COLS)
) (
   input  logic                clk,
   input  logic                we_i,
   input  logic [CW-1:0]       col_i [BYTE_W],
   input  logic [1:0]          row_i [BYTE_W],
   input  logic [BYTE_W-1:0]   bit_i,
   input  logic [CW-1:0]       rd_addr_i,
   output logic [NUM_ROWS-1:0] rd_data_o
);
   logic [NUM_ROWS-1:0] cells_q [COLS];

   always_ff @(posedge clk) begin
      if (we_i) begin
         for (int j = 0; j < int'(BYTE_W); j++)
            cells_q[col_i[j]][row_i[j]] <= bit_i[j];
      end
   end

   assign rd_data_o = ({1'b0, rd_addr_i} < (CW+1)'(COLS)) ? cells_q[rd_addr_i] : '0;
endmodule

// File: rtl/lcd_seg_packer.sv
module lcd_seg_packer
   import lcd_pack_pkg::*;
#(
   parameter int unsigned COLS   = 160,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned CW    = $clog2(COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we_i,
   input  logic [1:0]        mode_sel_i,
   input  logic              ptr_ld_i,
   input  logic [CW-1:0]     ptr_val_i,
   input  logic              byte_vld_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic [CW-1:0]     rd_addr_i,
   output logic [3:0]        rd_data_o,
   output logic [CW-1:0]     ptr_o
);
   if (COLS < BYTE_W) begin : g_chk_cols
      $error("COLS must be at least BYTE_W");
   end
   if (BYTE_W < 1) begin : g_chk_byte
      $error("BYTE_W must be positive");
   end
   if (NUM_ROWS != 4) begin : g_chk_rows
      $error("row count must be 4");
   end

   mux_mode_e     mode_q;
   logic [CW-1:0] ptr_w;
   logic [CW-1:0] step_w;
   logic [CW-1:0] wcol_w [BYTE_W];
   logic [1:0]    wrow_w [BYTE_W];
   logic [BYTE_W-1:0] wbit_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mode_q <= MUX_STATIC;
      else if (mode_we_i) mode_q <= mux_mode_e'(mode_sel_i);
   end

   lcd_bit_mapper #(.COLS(COLS), .BYTE_W(BYTE_W), .CW(CW)) u_map (
      .mode_i (mode_q),
      .base_i (ptr_w),
      .byte_i (byte_i),
      .col_o  (wcol_w),
      .row_o  (wrow_w),
      .bit_o  (wbit_w),
      .step_o (step_w)
   );

   lcd_col_ptr #(.COLS(COLS), .CW(CW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv_i    (byte_vld_i),
      .step_i   (step_w),
      .ld_i     (ptr_ld_i),
      .ld_val_i (ptr_val_i),
      .ptr_o    (ptr_w)
   );

   lcd_bitmap_mem #(.COLS(COLS), .BYTE_W(BYTE_W), .CW(CW)) u_mem (
      .clk       (clk),
      .we_i      (byte_vld_i),
      .col_i     (wcol_w),
      .row_i     (wrow_w),
      .bit_i     (wbit_w),
      .rd_addr_i (rd_addr_i),
      .rd_data_o (rd_data_o)
   );

   assign ptr_o = ptr_w;
endmodule

// File: rtl/lcd_seg_packer_chk.sv
module lcd_seg_packer_chk #(
   parameter int unsigned COLS   = 160,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CW     = $clog2(COLS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mode_we_i,
   input logic [1:0]    mode_sel_i,
   input logic [1:0]    mode_q,
   input logic          ptr_ld_i,
   input logic [CW-1:0] ptr_val_i,
   input logic          byte_vld_i,
   input logic [CW-1:0] rd_addr_i,
   input logic [3:0]    rd_data_o,
   input logic [CW-1:0] ptr_o
);
   logic ld_ok;
   assign ld_ok = ptr_ld_i && (int'(ptr_val_i) < int'(COLS));

   function automatic int step_of(logic [1:0] m);
      return (int'(BYTE_W) + int'(m)) / (int'(m) + 1);
   endfunction

   // R5 and R6: advance by the mode's span, modulo the column count
   a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_i && !ld_ok) |=>
      int'(ptr_o) == (int'($past(ptr_o)) + step_of($past(mode_q))) % int'(COLS));

   // R7: a legal load wins
   a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld_ok |=> ptr_o == $past(ptr_val_i));

   // R5 and R7: no byte and no legal load leaves the pointer alone
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_vld_i && !ld_ok) |=> $stable(ptr_o));

   // R6: pointer always in range
   a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr_o) < int'(COLS));

   // R10: mode changes only through its strobe
   a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_we_i |=> $stable(mode_q));

   a_r10_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
      mode_we_i |=> mode_q == $past(mode_sel_i));

   // R8: without a write, a held read address returns a held word
   a_r8_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_vld_i |=> (!$stable(rd_addr_i) || $stable(rd_data_o)));
endmodule

bind lcd_seg_packer lcd_seg_packer_chk #(.COLS(COLS), .BYTE_W(BYTE_W), .CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_we_i  (mode_we_i),
   .mode_sel_i (mode_sel_i),
   .mode_q     (mode_q),
   .ptr_ld_i   (ptr_ld_i),
   .ptr_val_i  (ptr_val_i),
   .byte_vld_i (byte_vld_i),
   .rd_addr_i  (rd_addr_i),
   .rd_data_o  (rd_data_o),
   .ptr_o      (ptr_o)
);

// File: tb/lcd_seg_packer_test.sv
module lcd_seg_packer_test;
   localparam int COLS       = 160;
   localparam int BYTE_W     = 8;
   localparam int CW         = $clog2(COLS);
   localparam int CLK_PERIOD = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_we = 1'b0;
   logic [1:0]    mode_sel = '0;
   logic          ptr_ld = 1'b0;
   logic [CW-1:0] ptr_val = '0;
   logic          byte_vld = 1'b0;
   logic [7:0]    byte_d = '0;
   logic [CW-1:0] rd_addr = '0;
   logic [3:0]    rd_data;
   logic [CW-1:0] ptr_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit cmp_en  = 1'b0;
   bit done    = 1'b0;
   int sweep   = 0;

   // behavioural reference
   logic [3:0] ref_mem   [COLS];
   logic [3:0] ref_known [COLS];
   int ref_ptr  = 0;
   int ref_mode = 0;
   int m_n, m_c, m_r;

   always #(CLK_PERIOD/2) clk = ~clk;

   lcd_seg_packer #(.COLS(COLS), .BYTE_W(BYTE_W)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_we_i  (mode_we),
      .mode_sel_i (mode_sel),
      .ptr_ld_i   (ptr_ld),
      .ptr_val_i  (ptr_val),
      .byte_vld_i (byte_vld),
      .byte_i     (byte_d),
      .rd_addr_i  (rd_addr),
      .rd_data_o  (rd_data),
      .ptr_o      (ptr_o)
   );

   initial begin
      for (int c = 0; c < COLS; c++) begin
         ref_mem[c]   = '0;
         ref_known[c] = '0;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         ref_ptr  = 0;
         ref_mode = 0;
      end else begin
         m_n = ref_mode + 1;
         if (byte_vld) begin
            for (int j = 0; j < 8; j++) begin
               m_c = (ref_ptr + j / m_n) % COLS;
               m_r = j % m_n;
               ref_mem[m_c][m_r]   = byte_d[7-j];
               ref_known[m_c][m_r] = 1'b1;
            end
         end
         if (ptr_ld && int'(ptr_val) < COLS) ref_ptr = int'(ptr_val);
         else if (byte_vld) ref_ptr = (ref_ptr + (8 + m_n - 1) / m_n) % COLS;
         if (mode_we) ref_mode = int'(mode_sel);
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // per-clock comparison against the reference
   always @(negedge clk) begin
      if (rst_n && cmp_en) begin
         chk("R5 pointer", int'(ptr_o), ref_ptr);
         if (int'(rd_addr) < COLS)
            chk("R8 scan word", int'(rd_data & ref_known[rd_addr]),
                int'(ref_mem[rd_addr] & ref_known[rd_addr]));
      end
   end

   task automatic drive(bit bv, logic [7:0] b, bit mw, logic [1:0] m,
                        bit pl, int pv, int ra);
      @(negedge clk);
      #1;
      byte_vld = bv;  byte_d   = b;
      mode_we  = mw;  mode_sel = m;
      ptr_ld   = pl;  ptr_val  = CW'(pv);
      rd_addr  = CW'(ra);
   endtask

   task automatic idle();
      drive(0, 8'h00, 0, 2'd0, 0, 0, sweep);
      sweep = (sweep + 1) % COLS;
   endtask

   task automatic put(logic [7:0] b);
      drive(1, b, 0, 2'd0, 0, 0, sweep);
      sweep = (sweep + 1) % COLS;
   endtask

   task automatic set_mode(int m);
      drive(0, 8'h00, 1, 2'(m), 0, 0, 0);
   endtask

   task automatic load(int v);
      drive(0, 8'h00, 0, 2'd0, 1, v, 0);
   endtask

   task automatic peek(int col, string tag);
      drive(0, 8'h00, 0, 2'd0, 0, 0, col);
      #1;
      chk(tag, int'(rd_data & ref_known[col]), int'(ref_mem[col] & ref_known[col]));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] pat;
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1 rst_n = 1'b1;
      cmp_en = 1'b1;
      #1 chk("R10 reset pointer", int'(ptr_o), 0);

      // R10 / R1: static mode right after reset
      put(8'hA5);
      for (int c = 0; c < 8; c++) begin
         drive(0, 8'h00, 0, 2'd0, 0, 0, c);
         #1 chk("R1 static bit after reset R10", int'(rd_data[0]), int'(pat_bit(8'hA5, c)));
      end
      #1 chk("R5 static advance", int'(ptr_o), 8);

      // R4 / R6: fill everything in 1:4, pointer comes back to 0
      set_mode(3);
      load(0);
      for (int i = 0; i < COLS / 2; i++) put(8'($urandom));
      @(posedge clk);
      #1 chk("R6 full wrap", int'(ptr_o), 0);
      for (int i = 0; i < COLS; i++) idle();
      peek(1, "R4 column word");

      // R3: third column row 2 preserved
      set_mode(2);
      load(10);
      pat = 8'b1011_1001;
      drive(1, pat, 0, 2'd0, 0, 0, 0);
      peek(10, "R3 first column");
      peek(11, "R3 second column");
      peek(12, "R3 third column");
      chk("R3 advance", int'(ptr_o), 13);
      for (int i = 0; i < 60; i++) put(8'($urandom));

      // R2
      set_mode(1);
      load(30);
      put(8'h6C);
      for (int c = 30; c < 34; c++) peek(c, "R2 pair word");
      for (int i = 0; i < 50; i++) put(8'($urandom));

      // R1 random
      set_mode(0);
      for (int i = 0; i < 30; i++) put(8'($urandom));
      peek(ref_ptr - 1 < 0 ? COLS - 1 : ref_ptr - 1, "R1 static word");

      // R6 wrap from 158
      load(158);
      put(8'hF0);
      @(posedge clk);
      #1 chk("R6 wrap pointer", int'(ptr_o), 6);
      peek(159, "R6 last column");
      peek(0, "R6 first column");

      // R7 ignored load, then load with byte in same cycle
      load(200);
      @(posedge clk);
      #1 chk("R7 ignored load", int'(ptr_o), 6);
      set_mode(3);
      drive(1, 8'h3C, 0, 2'd0, 1, 40, 0);
      @(posedge clk);
      #1 chk("R7 load over advance", int'(ptr_o), 40);
      peek(6, "R7 byte at old pointer");
      peek(7, "R7 byte at old pointer");

      // R10: mode write with byte in same cycle uses old mode (1:4)
      drive(1, 8'h81, 1, 2'd0, 0, 0, 0);
      @(posedge clk);
      #1 chk("R10 old mode on same cycle", int'(ptr_o), 42);

      // R8 same-cycle read returns old data
      drive(1, 8'hFF, 0, 2'd0, 0, 0, 42);
      #1 chk("R8 same-cycle read", int'(rd_data & ref_known[42]),
             int'(ref_mem[42] & ref_known[42]));

      // R9 out-of-range read
      drive(0, 8'h00, 0, 2'd0, 0, 0, 200);
      #1 chk("R9 out-of-range read", int'(rd_data), 0);

      for (int i = 0; i < COLS; i++) idle();
      finish_run();
   end

   function automatic logic pat_bit(logic [7:0] b, int c);
      return b[7-c];
   endfunction
endmodule